// File: doc/BRIEF.md
# Re-encoding Bit Error Rate Monitor

This block estimates the channel bit error rate behind a convolutional decoder. Every decoded data bit goes through a local copy of the constraint-length-7 encoder. The symbols it regenerates are compared with the hard decisions of the received symbols that produced that bit, after the decoder has delayed them to line up. A mismatch is taken to be a channel error on that symbol.

Each symbol gets its own error flag, and a combined flag summarises the bit. Errors are also counted over a measurement window whose length is a programmed number of thousands of decoded bits. The count goes through a divide-by-8 prescaler into a 16-bit accumulator that saturates. At the close of each window the accumulated value is latched as the readable result, the counters restart, and an interrupt is raised for one symbol period.

Top module: `ber_monitor`

## Requirements
- R1: The re-encoder forms a 7-bit window with the newest decoded bit at bit 6 and the bit taken six strobes earlier at bit 0. Each regenerated symbol is the XOR of the window bits selected by its generator: 171 octal for G1, 133 octal for G2 and 145 octal for G3. When the received symbols match an encoded stream, every error flag stays low.
- R2: `g_err[0]`, `g_err[1]` and `g_err[2]` are the mismatch flags for G1, G2 and G3. They are updated on the clock edge where `sym_valid` is high and hold their value until the next strobe.
- R3: `bit_err` is the OR of the G1 and G2 flags, plus the G3 flag when `rate_third` is 1. When `rate_third` is 0, a G3 mismatch sets `g_err[2]` but affects neither `bit_err` nor the error count.
- R4: A measurement window is 1000 × `period_units` strobes long. It closes on the last strobe of that window.
- R5: Counted errors (up to three per strobe) feed a modulo-8 prescaler. Only its carries increment the accumulator, so the latched count equals floor(errors/8). This includes errors on the final strobe of the window.
- R6: Once the accumulator reaches 0xFFFF it stays there for the rest of the window. A window with exactly enough errors to reach 0xFFFF also reads 0xFFFF.
- R7: When a window closes, the result is latched into `ber_count`, and the prescaler, accumulator and period counter clear, so no remainder carries over. `ber_count` changes only when a window closes.
- R8: `ber_irq` goes high in the cycle after the closing strobe and drops at the next strobe.
- R9: While `period_units` is 0, the counters are held clear, no window closes, `ber_irq` does not rise and `ber_count` keeps its value. Writing a non-zero value starts a fresh window.
- R10: Synchronous active-low reset clears all outputs and the re-encoder history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | One-cycle strobe per decoded bit |
| dec_bit | input | 1 | Decoded data bit |
| rx_hard | input | 3 | Aligned received hard symbols: bit 0 = G1, bit 1 = G2, bit 2 = G3 |
| rate_third | input | 1 | 1 = three symbols per bit, 0 = two |
| period_units | input | 24 | Window length in thousands of bits; 0 disables |
| g_err | output | 3 | Per-symbol mismatch flags (G1, G2, G3) |
| bit_err | output | 1 | Combined error flag for the current bit |
| ber_count | output | 16 | Latched error count of the last window |
| ber_irq | output | 1 | New-result interrupt |

## Verification
Two pairs of events can land on the same strobe. A prescaler carry can coincide with the window close, and the accumulator can saturate in the window it is latched from. The bench provokes the first by placing exactly eight G1 flips on the last eight bits of a window and expects a count of 1, not 0. It provokes the second with a reduced-width instance driven past its ceiling, and also with one that reaches the ceiling exactly. A window that holds only four errors, run straight after one that left a remainder of four, shows whether the close really clears the prescaler.

// File: rtl/ber_pkg.sv
// Package: shared constants for the BER monitor.
// Assumes three generator polynomials and at most three counted errors per strobe.
package ber_pkg;
    localparam int NUM_GEN = 3;
    localparam int NERR_W  = 2;
endpackage

// File: rtl/ber_reencoder.sv
// Module: re-encodes the decoded bit stream with the rate-1/3 convolutional code.
// Assumes GENS packs {G3, G2, G1}; window bit K-1 is the newest bit.
module ber_reencoder #(
    parameter int unsigned            K    = 7,
    parameter logic [3*K-1:0]         GENS = {7'o145, 7'o133, 7'o171}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sym_valid,
    input  logic                         dec_bit,
    output logic [ber_pkg::NUM_GEN-1:0]  sym
);
    logic [K-2:0] hist;
    logic [K-1:0] win;

    // window of the current bit and the K-1 previous bits
    assign win = {dec_bit, hist};

    // history shift on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         hist <= '0;
        else if (sym_valid) hist <= win[K-1:1];
    end

    // one parity tree per generator
    for (genvar g = 0; g < ber_pkg::NUM_GEN; g++) begin : g_gen
        assign sym[g] = ^(win & GENS[g*K +: K]);
    end
endmodule

// File: rtl/ber_compare.sv
// Module: compares regenerated with received symbols and registers the flags.
// Assumes rx_hard is already aligned to the decoded bit on the same strobe.
module ber_compare (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sym_valid,
    input  logic                         rate_third,
    input  logic [ber_pkg::NUM_GEN-1:0]  sym,
    input  logic [ber_pkg::NUM_GEN-1:0]  rx_hard,
    output logic [ber_pkg::NUM_GEN-1:0]  g_err,
    output logic                         bit_err,
    output logic [ber_pkg::NERR_W-1:0]   n_err
);
    logic [ber_pkg::NUM_GEN-1:0] raw;
    logic [ber_pkg::NUM_GEN-1:0] counted;

    // mismatch per symbol, G3 counted only at rate 1/3
    always_comb begin
        raw     = sym ^ rx_hard;
        counted = {raw[2] & rate_third, raw[1:0]};
        n_err   = ber_pkg::NERR_W'(counted[0]) + ber_pkg::NERR_W'(counted[1])
                + ber_pkg::NERR_W'(counted[2]);
    end

    // flags hold between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_err   <= '0;
            bit_err <= 1'b0;
        end else if (sym_valid) begin
            g_err   <= raw;
            bit_err <= |counted;
        end
    end

    // R3
    flag_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> (g_err != '0));
    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(g_err));
endmodule

// File: rtl/ber_period_timer.sv
// Module: counts strobes in units of UNIT_BITS and flags the window close.
// Assumes UNIT_BITS >= 2; a zero period holds the counters cleared.
module ber_period_timer #(
    parameter int unsigned UNIT_BITS = 1000,
    parameter int unsigned PERIOD_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic [PERIOD_W-1:0] period_units,
    output logic                period_end,
    output logic                idle
);
    localparam int unsigned DIV_W = $clog2(UNIT_BITS);

    logic [DIV_W-1:0]    div_cnt;
    logic [PERIOD_W-1:0] unit_cnt;
    logic                last_div;
    logic                last_unit;

    // terminal-count decode; >= keeps a shrunk period from running away
    always_comb begin
        idle       = (period_units == '0);
        last_div   = (div_cnt == DIV_W'(UNIT_BITS - 1));
        last_unit  = (unit_cnt >= period_units - PERIOD_W'(1));
        period_end = sym_valid && !idle && last_div && last_unit;
    end

    // divide-by-UNIT_BITS prescaler feeding the unit counter
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            div_cnt  <= '0;
            unit_cnt <= '0;
        end else if (sym_valid) begin
            if (last_div) begin
                div_cnt  <= '0;
                unit_cnt <= last_unit ? '0 : unit_cnt + PERIOD_W'(1);
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < DIV_W'(UNIT_BITS));
endmodule

// File: rtl/ber_err_accum.sv
// Module: divide-by-2^PRE_W prescaler, saturating accumulator, result latch, interrupt.
// Assumes at most three errors per strobe and PRE_W >= 2 (one carry per strobe).
module ber_err_accum #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PRE_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sym_valid,
    input  logic [ber_pkg::NERR_W-1:0]  n_err,
    input  logic                        period_end,
    input  logic                        idle,
    output logic [CNT_W-1:0]            ber_count,
    output logic                        ber_irq
);
    localparam int unsigned SUM_W   = PRE_W + ber_pkg::NERR_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] acc;
    logic [SUM_W-1:0] sum;
    logic             carry;
    logic [CNT_W-1:0] acc_next;

    // prescaler add and saturating increment on carry
    always_comb begin
        sum      = SUM_W'(pre) + SUM_W'(n_err);
        carry    = (sum[SUM_W-1:PRE_W] != '0);
        acc_next = (carry && acc != CNT_MAX) ? acc + CNT_W'(1) : acc;
    end

    // accumulate, latch at window close, run the interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre       <= '0;
            acc       <= '0;
            ber_count <= '0;
            ber_irq   <= 1'b0;
        end else if (idle) begin
            pre <= '0;
            acc <= '0;
            if (sym_valid) ber_irq <= 1'b0;
        end else if (sym_valid) begin
            if (period_end) begin
                ber_count <= acc_next;
                pre       <= '0;
                acc       <= '0;
                ber_irq   <= 1'b1;
            end else begin
                pre     <= sum[PRE_W-1:0];
                acc     <= acc_next;
                ber_irq <= 1'b0;
            end
        end
    end

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == CNT_MAX && !period_end && !idle) |=> acc == CNT_MAX);
    // R7
    count_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ber_count != $past(ber_count)) |-> ber_irq);
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ber_irq && sym_valid && !period_end) |=> !ber_irq);
    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !period_end && !idle) |=> (acc - $past(acc)) <= CNT_W'(1));
endmodule

// File: rtl/ber_monitor.sv
// Module: top of the re-encoding BER monitor.
// Assumes one strobe per decoded bit with received symbols already aligned.
module ber_monitor #(
    parameter int unsigned K         = 7,
    parameter logic [6:0]  GEN1      = 7'o171,
    parameter logic [6:0]  GEN2      = 7'o133,
    parameter logic [6:0]  GEN3      = 7'o145,
    parameter int unsigned UNIT_BITS = 1000,
    parameter int unsigned PERIOD_W  = 24,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PRE_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic                dec_bit,
    input  logic [2:0]          rx_hard,
    input  logic                rate_third,
    input  logic [PERIOD_W-1:0] period_units,
    output logic [2:0]          g_err,
    output logic                bit_err,
    output logic [CNT_W-1:0]    ber_count,
    output logic                ber_irq
);
    logic [2:0]                       sym;
    logic [ber_pkg::NERR_W-1:0]       n_err;
    logic                             period_end;
    logic                             idle;

    ber_reencoder #(.K(K), .GENS({GEN3, GEN2, GEN1})) u_enc (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .dec_bit(dec_bit), .sym(sym));

    ber_compare u_cmp (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .rate_third(rate_third), .sym(sym), .rx_hard(rx_hard),
        .g_err(g_err), .bit_err(bit_err), .n_err(n_err));

    ber_period_timer #(.UNIT_BITS(UNIT_BITS), .PERIOD_W(PERIOD_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .period_units(period_units), .period_end(period_end), .idle(idle));

    ber_err_accum #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .n_err(n_err),
        .period_end(period_end), .idle(idle),
        .ber_count(ber_count), .ber_irq(ber_irq));

    // R9
    idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_units == '0 && !ber_irq) |=> !ber_irq);
    // R3
    g3_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !rate_third && rx_hard[1:0] == sym[1:0]) |=> !bit_err);
endmodule

// File: tb/tb_ber_monitor.sv
module tb_ber_monitor;
    localparam logic [6:0] P1 = 7'o171;
    localparam logic [6:0] P2 = 7'o133;
    localparam logic [6:0] P3 = 7'o145;
    localparam int NV = 7;
    // vector fields: [12] rate_third, [11:9] flip mask {G3,G2,G1}, [8:0] flip every N bits
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 3'b001, 9'd1},    // R5: 1000 errors -> 125
        {1'b0, 3'b011, 9'd4},    // R5: 500 errors -> 62, remainder 4
        {1'b0, 3'b001, 9'd250},  // R7: 4 errors -> 0 if prescaler cleared
        {1'b0, 3'b100, 9'd1},    // R3: G3 ignored at rate 1/2 -> 0
        {1'b1, 3'b111, 9'd3},    // R3: 1002 errors -> 125
        {1'b1, 3'b110, 9'd7},    // R3: 286 errors -> 35
        {1'b1, 3'b000, 9'd1}     // R1: clean stream -> 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        dec_bit = 1'b0;
    logic [2:0]  rx_m = '0, rx_s = '0;
    logic        rate_third = 1'b0;
    logic [23:0] period_m = 24'd1, period_s = 24'd0;
    logic [2:0]  g_err, g_err_s;
    logic        bit_err, bit_err_s, ber_irq, ber_irq_s;
    logic [15:0] ber_count;
    logic [3:0]  ber_count_s;

    int n_cmp = 0;
    int n_bad = 0;
    logic [5:0]  hist = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    ber_monitor dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .dec_bit(dec_bit),
        .rx_hard(rx_m), .rate_third(rate_third), .period_units(period_m),
        .g_err(g_err), .bit_err(bit_err), .ber_count(ber_count), .ber_irq(ber_irq));

    ber_monitor #(.UNIT_BITS(10), .CNT_W(4)) dut_small (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .dec_bit(dec_bit),
        .rx_hard(rx_s), .rate_third(rate_third), .period_units(period_s),
        .g_err(g_err_s), .bit_err(bit_err_s), .ber_count(ber_count_s), .ber_irq(ber_irq_s));

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one decoded bit: encode it, apply flips, strobe for one cycle
    task automatic step(input logic [2:0] fm, input logic [2:0] fs);
        logic       d;
        logic [6:0] w;
        logic [2:0] s;
        d    = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        w    = {d, hist};
        s    = {^(w & P3), ^(w & P2), ^(w & P1)};
        hist = w[6:1];
        @(negedge clk);
        sym_valid = 1'b1; dec_bit = d; rx_m = s ^ fm; rx_s = s ^ fs;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int flag_bad, irq_bad, errs;
        logic [2:0] f, eff;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 count after reset", ber_count, 0);
        check("R10 irq after reset", ber_irq, 0);
        check("R10 flags after reset", {g_err, bit_err}, 0);
        rst_n = 1'b1;

        // vector table walk, one 1000-bit window each
        for (int v = 0; v < NV; v++) begin
            rate_third = VEC[v][12];
            flag_bad = 0; irq_bad = 0; errs = 0;
            for (int i = 0; i < 1000; i++) begin
                f   = (i % int'(VEC[v][8:0]) == 0) ? VEC[v][11:9] : 3'b000;
                step(f, 3'b000);
                eff = rate_third ? f : (f & 3'b011);
                errs += $countones(eff);
                if (g_err !== f) flag_bad++;
                if (bit_err !== (|eff)) flag_bad++;
                if (i < 999 && ber_irq) irq_bad++;
            end
            check("R1 R2 R3 flags per bit", flag_bad, 0);
            check("R4 R8 irq at window close", ber_irq, 1);
            check("R8 irq quiet inside window", irq_bad, 0);
            check("R5 R7 latched count", ber_count, errs / 8);
        end

        // R8: interrupt drops at the next strobe
        step(3'b000, 3'b000);
        check("R8 irq drop", ber_irq, 0);

        // R9: zero period disables measurement
        period_m = 24'd0;
        irq_bad = 0;
        for (int i = 0; i < 1500; i++) begin
            step(3'b001, 3'b000);
            if (ber_irq) irq_bad++;
        end
        check("R9 no irq at zero period", irq_bad, 0);
        check("R9 count retained", ber_count, 0);

        // R9 fresh start, R5 carry on the closing strobe
        period_m = 24'd1;
        for (int i = 0; i < 1000; i++) begin
            step((i >= 992) ? 3'b001 : 3'b000, 3'b000);
            if (i == 998) begin
                check("R7 count held before close", ber_count, 0);
                check("R4 no early irq", ber_irq, 0);
            end
        end
        check("R4 R9 irq after restart", ber_irq, 1);
        check("R5 carry on final bit", ber_count, 1);

        // R6: saturation on the 4-bit instance, 100-bit windows
        rate_third = 1'b1;
        period_s = 24'd10;
        for (int i = 0; i < 100; i++) step(3'b000, 3'b111);
        check("R6 saturated count", ber_count_s, 15);
        check("R8 small irq", ber_irq_s, 1);
        for (int i = 0; i < 100; i++) step(3'b000, (i < 60) ? 3'b011 : 3'b000);
        check("R6 exact ceiling", ber_count_s, 15);
        for (int i = 0; i < 100; i++) step(3'b000, 3'b001);
        check("R7 after saturation", ber_count_s, 12);

        // R10: mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 count cleared", ber_count_s, 0);
        check("R10 main count cleared", ber_count, 0);
        check("R10 irq cleared", ber_irq_s, 0);
        rst_n = 1'b1;
        hist = '0;
        flag_bad = 0;
        for (int i = 0; i < 20; i++) begin
            step(3'b000, 3'b000);
            if (g_err !== 3'b000 || g_err_s !== 3'b000) flag_bad++;
        end
        check("R10 R1 history cleared", flag_bad, 0);

        summary();
        $finish;
    end
endmodule